// File: doc/BRIEF.md
# Color-Checked Secondary Cache Tag Store

This block holds the tag state for a physically tagged, direct-mapped secondary cache. Every line stores a valid flag, a dirty flag, a physical tag and a three-bit virtual color. The color is bits 14..12 of the virtual address that last filled the line or claimed it. A request supplies the line index, the physical tag, the requester's color and an operation code. One clock after the request is accepted, the block returns the lookup outcome.

A read or write whose physical tag matches but whose color differs does not hit. It is reported as a virtual coherency exception, and the line is left exactly as it was. Handler software resolves the conflict one line at a time, in one of two ways. It can re-color the line with the requester's color, or it can write back and invalidate the line. A fill command installs a new line after a miss. The data array, the primary caches and the refill sequencing sit outside this block.

Top module: `l2_color_tag`

## Requirements
- R1: While reset is low and through the reset cycle, `rsp_valid` is 0 and `req_ready` is 0. After reset, `req_ready` is 1 and every line is invalid, so any read is reported as a miss.
- R2: An accepted request (`req_valid` and `req_ready` both 1 at a clock edge) produces exactly one response cycle with `rsp_valid`=1, registered at that edge. Otherwise `rsp_valid` is 0. At most one of hit, miss and vce is set.
- R3: Op codes are READ=0 and WRITE=1. A read or write hits when the line is valid, the tag is equal and all three color bits are equal. It misses when the line is invalid or the tag differs.
- R4: A read or write that matches the tag on a valid line but differs in any color bit sets vce, not hit.
- R5: A vce response changes no line state. A write that gets vce does not set the dirty flag, and the line stays valid.
- R6: FILL (code 2) writes the tag and the color, sets valid and clears dirty. Its response has hit, miss, vce and wb_req all at 0.
- R7: A write that hits sets the line's dirty flag.
- R8: SET_COLOR (code 3) on a tag match overwrites the stored color with the request color and responds hit. Later accesses with the new color hit, and accesses with the old color get vce.
- R9: INVALIDATE (code 4) on a tag match clears valid, responds hit and never raises wb_req.
- R10: WB_INVALIDATE (code 5) on a tag match responds hit and clears valid. If the line was dirty it also raises wb_req, with `rsp_wb_tag` equal to the line's tag. Maintenance ops ignore the color.
- R11: A maintenance op (codes 3..5) that misses on the tag responds miss, with no vce and no wb_req, and leaves the resident line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts requests |
| req_op | input | 3 | Operation code |
| req_index | input | IDX_W | Line index from physical address |
| req_tag | input | TAG_W | Physical tag |
| req_color | input | COLOR_W | Virtual address bits 14..12 |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Hit / maintenance op applied |
| rsp_miss | output | 1 | Tag miss |
| rsp_vce | output | 1 | Virtual coherency exception |
| rsp_wb_req | output | 1 | Dirty line must be written back |
| rsp_wb_tag | output | TAG_W | Tag of the line to write back |

## Verification
The hardest case to reach is a vce on a write that must leave the dirty flag clear. Dirty state is not visible at the ports. The stimulus therefore fills a line clean and issues a write with a wrong color. It then performs a write-back-invalidate, and the lack of a wb_req shows that the write changed nothing. A second hard case is checking that a maintenance op which misses leaves the resident line intact. For that, the op is issued with a foreign tag, and the original line is then read under its own tag and color.

// File: rtl/l2ct_pkg.sv
// Shared types for the color-checked secondary cache tag store.
// Assumes the color field is narrow (a few bits) and the op code is 3 bits.
package l2ct_pkg;
    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_FILL      = 3'd2,
        OP_SET_COLOR = 3'd3,
        OP_INVAL     = 3'd4,
        OP_WB_INVAL  = 3'd5
    } l2ct_op_e;
endpackage

// File: rtl/l2ct_line_store.sv
// Per-line state storage: valid and dirty flags in flops, tag and color in
// plain arrays. Read is combinational at rd_idx; one write port updates a
// whole line at the clock edge. Assumes synchronous active-low reset
// only needs to clear the valid flags.
module l2ct_line_store #(
    parameter int IDX_W   = 6,
    parameter int TAG_W   = 18,
    parameter int COLOR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [COLOR_W-1:0] rd_color,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic               wr_dirty,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [COLOR_W-1:0] wr_color
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]   valid_q;
    logic [LINES-1:0]   dirty_q;
    logic [TAG_W-1:0]   tag_mem   [LINES];
    logic [COLOR_W-1:0] color_mem [LINES];

    // Flag update: reset invalidates every line, otherwise write one line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    // Tag and color update: no reset needed, guarded by the valid flag.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]   <= wr_tag;
            color_mem[wr_idx] <= wr_color;
        end
    end

    // Combinational read of the addressed line.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
        rd_tag   = tag_mem[rd_idx];
        rd_color = color_mem[rd_idx];
    end
endmodule

// File: rtl/l2ct_lookup.sv
// Compare and next-state logic. Given the addressed line and the request,
// decides hit/miss/vce/writeback and the line image to write back into the
// store. Purely combinational; assumes the caller gates with an accepted
// request.
module l2ct_lookup
    import l2ct_pkg::*;
#(
    parameter int TAG_W   = 18,
    parameter int COLOR_W = 3
) (
    input  logic               req_go,
    input  l2ct_op_e           op,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [COLOR_W-1:0] req_color,
    input  logic               ln_valid,
    input  logic               ln_dirty,
    input  logic [TAG_W-1:0]   ln_tag,
    input  logic [COLOR_W-1:0] ln_color,
    output logic               hit,
    output logic               miss,
    output logic               vce,
    output logic               wb_req,
    output logic [TAG_W-1:0]   wb_tag,
    output logic               upd_en,
    output logic               upd_valid,
    output logic               upd_dirty,
    output logic [TAG_W-1:0]   upd_tag,
    output logic [COLOR_W-1:0] upd_color
);
    logic tag_eq;
    logic color_eq;

    // Physical match and full-width color match.
    always_comb begin
        tag_eq   = ln_valid && (ln_tag == req_tag);
        color_eq = (ln_color == req_color);
    end

    // Outcome and line update per op.
    always_comb begin
        hit       = 1'b0;
        miss      = 1'b0;
        vce       = 1'b0;
        wb_req    = 1'b0;
        wb_tag    = ln_tag;
        upd_en    = 1'b0;
        upd_valid = ln_valid;
        upd_dirty = ln_dirty;
        upd_tag   = ln_tag;
        upd_color = ln_color;
        if (req_go) begin
            unique case (op)
                OP_READ, OP_WRITE: begin
                    if (!tag_eq) begin
                        miss = 1'b1;
                    end else if (!color_eq) begin
                        vce = 1'b1;
                    end else begin
                        hit = 1'b1;
                        if (op == OP_WRITE) begin
                            upd_en    = 1'b1;
                            upd_dirty = 1'b1;
                        end
                    end
                end
                OP_FILL: begin
                    upd_en    = 1'b1;
                    upd_valid = 1'b1;
                    upd_dirty = 1'b0;
                    upd_tag   = req_tag;
                    upd_color = req_color;
                end
                OP_SET_COLOR: begin
                    hit  = tag_eq;
                    miss = !tag_eq;
                    if (tag_eq) begin
                        upd_en    = 1'b1;
                        upd_color = req_color;
                    end
                end
                OP_INVAL, OP_WB_INVAL: begin
                    hit  = tag_eq;
                    miss = !tag_eq;
                    if (tag_eq) begin
                        upd_en    = 1'b1;
                        upd_valid = 1'b0;
                        upd_dirty = 1'b0;
                        wb_req    = (op == OP_WB_INVAL) && ln_dirty;
                    end
                end
                default: miss = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/l2ct_rsp_reg.sv
// Registers the lookup outcome into the one-cycle response. Assumes the
// inputs are already zero when no request is accepted.
module l2ct_rsp_reg #(
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             hit,
    input  logic             miss,
    input  logic             vce,
    input  logic             wb_req,
    input  logic [TAG_W-1:0] wb_tag,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_vce,
    output logic             rsp_wb_req,
    output logic [TAG_W-1:0] rsp_wb_tag
);
    // Capture the outcome of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_vce    <= 1'b0;
            rsp_wb_req <= 1'b0;
            rsp_wb_tag <= '0;
        end else begin
            rsp_valid  <= go;
            rsp_hit    <= hit;
            rsp_miss   <= miss;
            rsp_vce    <= vce;
            rsp_wb_req <= wb_req;
            rsp_wb_tag <= wb_req ? wb_tag : '0;
        end
    end

    // R2
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0({rsp_hit, rsp_miss, rsp_vce}));

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_vce || rsp_wb_req));

    // R10
    wb_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wb_req |-> (rsp_valid && rsp_hit));
endmodule

// File: rtl/l2_color_tag.sv
// Top of the color-checked secondary cache tag store. Wires the line store,
// the compare/next-state logic and the response register. Always ready
// once out of reset; one request per cycle, response one cycle later.
module l2_color_tag
    import l2ct_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int TAG_W   = 18,
    parameter int COLOR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [2:0]         req_op,
    input  logic [IDX_W-1:0]   req_index,
    input  logic [TAG_W-1:0]   req_tag,
    input  logic [COLOR_W-1:0] req_color,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic               rsp_vce,
    output logic               rsp_wb_req,
    output logic [TAG_W-1:0]   rsp_wb_tag
);
    logic               ready_q;
    logic               go;
    logic               ln_valid, ln_dirty;
    logic [TAG_W-1:0]   ln_tag;
    logic [COLOR_W-1:0] ln_color;
    logic               lk_hit, lk_miss, lk_vce, lk_wb;
    logic [TAG_W-1:0]   lk_wb_tag;
    logic               upd_en, upd_valid, upd_dirty;
    logic [TAG_W-1:0]   upd_tag;
    logic [COLOR_W-1:0] upd_color;
    l2ct_op_e           op;

    // Ready rises on the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign req_ready = ready_q;
    assign go        = req_valid && ready_q;
    assign op        = l2ct_op_e'(req_op);

    l2ct_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .COLOR_W(COLOR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_index),
        .rd_valid (ln_valid),
        .rd_dirty (ln_dirty),
        .rd_tag   (ln_tag),
        .rd_color (ln_color),
        .wr_en    (upd_en),
        .wr_idx   (req_index),
        .wr_valid (upd_valid),
        .wr_dirty (upd_dirty),
        .wr_tag   (upd_tag),
        .wr_color (upd_color)
    );

    l2ct_lookup #(.TAG_W(TAG_W), .COLOR_W(COLOR_W)) u_lookup (
        .req_go    (go),
        .op        (op),
        .req_tag   (req_tag),
        .req_color (req_color),
        .ln_valid  (ln_valid),
        .ln_dirty  (ln_dirty),
        .ln_tag    (ln_tag),
        .ln_color  (ln_color),
        .hit       (lk_hit),
        .miss      (lk_miss),
        .vce       (lk_vce),
        .wb_req    (lk_wb),
        .wb_tag    (lk_wb_tag),
        .upd_en    (upd_en),
        .upd_valid (upd_valid),
        .upd_dirty (upd_dirty),
        .upd_tag   (upd_tag),
        .upd_color (upd_color)
    );

    l2ct_rsp_reg #(.TAG_W(TAG_W)) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .hit        (lk_hit),
        .miss       (lk_miss),
        .vce        (lk_vce),
        .wb_req     (lk_wb),
        .wb_tag     (lk_wb_tag),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_miss   (rsp_miss),
        .rsp_vce    (rsp_vce),
        .rsp_wb_req (rsp_wb_req),
        .rsp_wb_tag (rsp_wb_tag)
    );

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> rsp_valid);

    // R2
    rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && !go) |=> !rsp_valid);

    // R5
    vce_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_vce |-> !upd_en);

    // R11
    maint_miss_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss && req_op != 3'd2) |-> !upd_en);
endmodule

// File: tb/l2_color_tag_test.sv
// Scoreboard bench: driver pushes expected responses, monitor compares.
module l2_color_tag_test;
    localparam int IDX_W   = 6;
    localparam int TAG_W   = 18;
    localparam int COLOR_W = 3;

    localparam logic [2:0] RD = 3'd0, WR = 3'd1, FL = 3'd2, SC = 3'd3, IV = 3'd4, WI = 3'd5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [2:0]         req_op = '0;
    logic [IDX_W-1:0]   req_index = '0;
    logic [TAG_W-1:0]   req_tag = '0;
    logic [COLOR_W-1:0] req_color = '0;
    logic               rsp_valid, rsp_hit, rsp_miss, rsp_vce, rsp_wb_req;
    logic [TAG_W-1:0]   rsp_wb_tag;

    typedef struct {
        logic [4:0]       flags;  // hit, miss, vce, wb
        logic [TAG_W-1:0] wbtag;
        string            tagname;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #5 clk = ~clk;

    l2_color_tag #(.IDX_W(IDX_W), .TAG_W(TAG_W), .COLOR_W(COLOR_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_index(req_index), .req_tag(req_tag), .req_color(req_color),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_vce(rsp_vce),
        .rsp_wb_req(rsp_wb_req), .rsp_wb_tag(rsp_wb_tag)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Drive one request and push its expected response.
    task automatic issue(input logic [2:0] op, input int idx, input logic [TAG_W-1:0] tag,
                         input int col, input bit h, input bit m, input bit v, input bit w,
                         input logic [TAG_W-1:0] wt, input string rq);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_index = IDX_W'(idx);
        req_tag   = tag;
        req_color = COLOR_W'(col);
        e.flags   = {1'b0, h, m, v, w};
        e.wbtag   = w ? wt : '0;
        e.tagname = rq;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the oldest expected item for every response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tagname, {27'd0, 1'b0, rsp_hit, rsp_miss, rsp_vce, rsp_wb_req},
                      {27'd0, e.flags});
                check({e.tagname, " wb_tag"}, 32'(rsp_wb_tag), 32'(e.wbtag));
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        check("R1 req_ready in reset", 32'(req_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req_ready after reset", 32'(req_ready), 32'd1);
        check("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);

        issue(RD, 5, 18'h0A0A, 3, 0,1,0,0, 0, "R1 read after reset misses");
        issue(FL, 5, 18'h0A0A, 3, 0,0,0,0, 0, "R6 fill response quiet");
        issue(RD, 5, 18'h0A0A, 3, 1,0,0,0, 0, "R3 read hit");
        issue(RD, 5, 18'h0A0A, 7, 0,0,1,0, 0, "R4 color bit2 differs vce");
        issue(RD, 5, 18'h0A0A, 2, 0,0,1,0, 0, "R4 color bit0 differs vce");
        issue(RD, 5, 18'h0B0B, 3, 0,1,0,0, 0, "R3 tag differs miss");
        issue(WR, 5, 18'h0A0A, 1, 0,0,1,0, 0, "R5 write vce");
        issue(SC, 5, 18'h0B0B, 1, 0,1,0,0, 0, "R11 set-color miss");
        issue(WI, 5, 18'h0B0B, 1, 0,1,0,0, 0, "R11 wb-inval miss");
        issue(RD, 5, 18'h0A0A, 3, 1,0,0,0, 0, "R11 line unchanged hit");
        issue(SC, 5, 18'h0A0A, 6, 1,0,0,0, 0, "R8 set-color hit");
        issue(RD, 5, 18'h0A0A, 6, 1,0,0,0, 0, "R8 new color hits");
        issue(RD, 5, 18'h0A0A, 3, 0,0,1,0, 0, "R8 old color vce");
        issue(WI, 5, 18'h0A0A, 0, 1,0,0,0, 0, "R5 vce write left clean");
        issue(RD, 5, 18'h0A0A, 6, 0,1,0,0, 0, "R10 invalidated line misses");
        idle(2);

        issue(FL, 9, 18'h3C3C, 2, 0,0,0,0, 0, "R6 fill idx9");
        issue(WR, 9, 18'h3C3C, 2, 1,0,0,0, 0, "R7 write hit");
        issue(WI, 9, 18'h3C3C, 5, 1,0,0,1, 18'h3C3C, "R10 dirty writeback");
        issue(RD, 9, 18'h3C3C, 2, 0,1,0,0, 0, "R10 line gone");
        issue(FL, 9, 18'h3C3C, 2, 0,0,0,0, 0, "R6 refill idx9");
        issue(WR, 9, 18'h3C3C, 2, 1,0,0,0, 0, "R7 write hit again");
        issue(IV, 9, 18'h3C3C, 4, 1,0,0,0, 0, "R9 invalidate no wb");
        issue(RD, 9, 18'h3C3C, 2, 0,1,0,0, 0, "R9 line gone");
        issue(FL, 12, 18'h1234, 1, 0,0,0,0, 0, "R6 fill idx12");
        issue(WR, 12, 18'h1234, 1, 1,0,0,0, 0, "R7 dirty idx12");
        issue(FL, 12, 18'h1234, 1, 0,0,0,0, 0, "R6 refill clears dirty");
        issue(IV, 12, 18'h2222, 1, 0,1,0,0, 0, "R11 inval miss");
        issue(WI, 12, 18'h1234, 1, 1,0,0,0, 0, "R6 clean after refill");
        issue(RD, 20, 18'h1234, 1, 0,1,0,0, 0, "R3 other index invalid");
        idle(3);
        check("R2 queue drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule